// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the control port of a data converter. An external host selects it, clocks in one instruction byte and one data byte, and either writes a configuration byte into a small register bank or reads one back. The serial pins are sampled through synchronizers by the block's own clock, so the serial clock must be several times slower than `clk`. Serial mode 0 is used: the host changes its data while the serial clock is low, and both sides sample on the rising edge.

The port's own control register at address 00h sets how the port behaves. It selects whether read data leaves on a dedicated output line or on the shared bidirectional data line. It also selects whether bytes travel most significant bit first or least significant bit first. The same register holds a self-clearing software reset, and it drives the sleep, power-down and reference-select outputs. The software reset returns every other register to zero. Address 01h holds a read-only version code. Addresses 02h to 11h are plain 8-bit configuration bytes that are visible to downstream logic on a flat bus.

Top module: `spi_cfg_bank`

## Requirements
- R1: After reset every register reads 0, except the version register. `cfg_sleep`, `cfg_pdn` and `cfg_ext_ref` are 0, and `spi_sdo` and `spi_sdio_oe` are 0.
- R2: A frame is 16 bits, sampled on rising `spi_sclk` edges while `spi_csn` is low. The first byte is the instruction: bit 7 is 1 for read and 0 for write, bits 6:5 are 0, and bits 4:0 are the address. The second byte is data. Registers 02h to 11h store and return all 8 bits written.
- R3: Register 00h bit 6 sets the bit order for both bytes, input and output. 0 sends the most significant bit first; 1 sends the least significant bit first.
- R4: Register 00h bit 7 sets the read line. With 0, read data appears on `spi_sdo` and `spi_sdio_oe` stays low. With 1, read data appears on `spi_sdio_o` with `spi_sdio_oe` high, and `spi_sdo` stays 0. Data bit k is valid before rising edge 9+k. Both lines go idle when the port is deselected.
- R5: `cfg_sleep` follows register 00h bit 4, `cfg_pdn` follows bit 3, and `cfg_ext_ref` follows bit 0.
- R6: Bits 2:1 of register 00h are reserved. They are stored as 0 and read as 0, whatever value is written.
- R7: Register 01h reads as the 4-bit `VERSION` parameter in its low nibble with zeros above it. Writes to it are ignored.
- R8: Writing 1 to register 00h bit 5 clears registers 01h to 11h one clock after the write lands. After that bit 5 reads 0, and the other bits of register 00h keep the values written.
- R9: If `spi_csn` rises before the 16th rising edge, the frame is aborted and no register changes.
- R10: Addresses 12h to 1Fh read as 0 and ignore writes. An instruction with bit 6 or bit 5 set reads 0 and writes nothing.
- R11: Clock edges after the 16th within the same selection are ignored. They do not change the addressed register or its neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Port select, active low |
| spi_sclk | input | 1 | Serial clock from host |
| spi_sdio_i | input | 1 | Serial data in (input side of shared line) |
| spi_sdio_o | output | 1 | Read data for the shared line |
| spi_sdio_oe | output | 1 | Drive enable for the shared line |
| spi_sdo | output | 1 | Dedicated read data line |
| cfg_sleep | output | 1 | Output current off |
| cfg_pdn | output | 1 | Power down all but the serial port |
| cfg_ext_ref | output | 1 | Select external reference |
| cfg_regs | output | NREG*8 | All registers as read, address 0 in the low byte |

## Verification
The bench targets the self-clearing reset. A design that cleared register 00h along with the rest, or left bit 5 set, would lose the sleep bit or keep resetting the bank. Aborted frames and frames with extra clocks are driven to catch a write that fires on a bit count other than exactly sixteen. Least-significant-first frames are run in both directions, because a port that reversed only the input bytes would return mirrored read data. Bidirectional reads are checked for a line that is left undriven or for read data that leaks onto the dedicated output. Masked and invalid writes to reserved bits, the version nibble, high addresses and malformed instructions must leave the visible state unchanged.

// File: rtl/spi_cfg_pkg.sv
`timescale 1ns/1ps
package spi_cfg_pkg;
    localparam int unsigned CFG_DW    = 8;
    localparam int unsigned CFG_AW    = 5;
    localparam int unsigned CFG_FRAME = 2 * CFG_DW;
    localparam int unsigned CFG_CW    = $clog2(CFG_FRAME + 1);
    localparam int unsigned CFG_BW    = $clog2(CFG_DW);

    // control register bit positions
    localparam int unsigned BIT_BIDIR  = 7;
    localparam int unsigned BIT_LSBF   = 6;
    localparam int unsigned BIT_SRST   = 5;
    localparam int unsigned BIT_SLEEP  = 4;
    localparam int unsigned BIT_PDN    = 3;
    localparam int unsigned BIT_EXTREF = 0;

    localparam logic [CFG_DW-1:0] CTRL_WMASK = 8'hF9;

    typedef logic [CFG_DW-1:0] cfg_byte_t;
    typedef logic [CFG_AW-1:0] cfg_addr_t;

    typedef struct packed {
        logic [CFG_CW-1:0] cnt;
        cfg_byte_t         sh;
        cfg_byte_t         ins;
        logic              sclk_prev;
        logic              wr_stb;
        cfg_byte_t         wr_data;
    } ser_state_t;
endpackage

// File: rtl/spi_cfg_sync.sv
`timescale 1ns/1ps
module spi_cfg_sync #(
    parameter int unsigned   W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] stg_d, stg_q;

        always_comb begin
            stg_d = {stg_q[0], d[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= {2{RST_VAL[g]}};
            else        stg_q <= stg_d;
        end

        assign q[g] = stg_q[1];
    end
endmodule

// File: rtl/spi_cfg_serial.sv
`timescale 1ns/1ps
module spi_cfg_serial
    import spi_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      csn_s,
    input  logic      sclk_s,
    input  logic      sdi_s,
    input  logic      lsb_first,
    input  cfg_byte_t rdata,
    output logic      wr_stb,
    output cfg_byte_t wr_data,
    output cfg_addr_t addr,
    output logic      cmd_ok,
    output logic      rd_phase,
    output logic      dout
);
    localparam logic [CFG_CW-1:0] C_INS   = CFG_CW'(CFG_DW);
    localparam logic [CFG_CW-1:0] C_FRAME = CFG_CW'(CFG_FRAME);

    ser_state_t         ser_d, ser_q;
    cfg_byte_t          shifted;
    logic               rise;
    logic [CFG_BW-1:0]  bsel;

    assign shifted = lsb_first ? {sdi_s, ser_q.sh[CFG_DW-1:1]}
                               : {ser_q.sh[CFG_DW-2:0], sdi_s};
    assign rise    = sclk_s && !ser_q.sclk_prev;
    assign cmd_ok  = (ser_q.ins[CFG_DW-2:CFG_AW] == '0);

    always_comb begin
        ser_d           = ser_q;
        ser_d.wr_stb    = 1'b0;
        ser_d.sclk_prev = sclk_s;
        if (csn_s) begin
            ser_d.cnt = '0;
        end else if (rise && (ser_q.cnt < C_FRAME)) begin
            ser_d.sh  = shifted;
            ser_d.cnt = ser_q.cnt + 1'b1;
            if (ser_q.cnt == C_INS - 1'b1) begin
                ser_d.ins = shifted;
            end
            if ((ser_q.cnt == C_FRAME - 1'b1) && !ser_q.ins[CFG_DW-1] && cmd_ok) begin
                ser_d.wr_stb  = 1'b1;
                ser_d.wr_data = shifted;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_q           <= '0;
            ser_q.sclk_prev <= 1'b0;
        end else begin
            ser_q <= ser_d;
        end
    end

    // data bit index equals the low bits of the count once the instruction is in
    assign bsel     = lsb_first ? ser_q.cnt[CFG_BW-1:0] : ~ser_q.cnt[CFG_BW-1:0];
    assign rd_phase = !csn_s && ser_q.ins[CFG_DW-1]
                      && (ser_q.cnt >= C_INS) && (ser_q.cnt < C_FRAME);
    assign dout     = rd_phase & rdata[bsel];
    assign wr_stb   = ser_q.wr_stb;
    assign wr_data  = ser_q.wr_data;
    assign addr     = ser_q.ins[CFG_AW-1:0];
endmodule

// File: rtl/spi_cfg_regs.sv
`timescale 1ns/1ps
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int unsigned NREG     = 18,
    parameter int unsigned VER_ADDR = 1,
    parameter logic [3:0]  VERSION  = 4'h5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_stb,
    input  cfg_byte_t              wr_data,
    input  cfg_addr_t              addr,
    input  logic                   cmd_ok,
    output cfg_byte_t              rdata,
    output logic [NREG*CFG_DW-1:0] regs_flat
);
    localparam cfg_byte_t VER_BYTE = {{(CFG_DW-4){1'b0}}, VERSION};

    typedef struct packed {
        logic [NREG-1:0][CFG_DW-1:0] bank;
    } bank_state_t;

    bank_state_t                 reg_d, reg_q;
    logic [NREG-1:0][CFG_DW-1:0] view;

    function automatic cfg_byte_t wmask(input int unsigned idx);
        if (idx == 0)             return CTRL_WMASK;
        else if (idx == VER_ADDR) return '0;
        else                      return '1;
    endfunction

    always_comb begin
        reg_d = reg_q;
        if (reg_q.bank[0][BIT_SRST]) begin
            for (int unsigned i = 1; i < NREG; i++) begin
                reg_d.bank[i] = '0;
            end
            reg_d.bank[0][BIT_SRST] = 1'b0;
        end else if (wr_stb) begin
            for (int unsigned i = 0; i < NREG; i++) begin
                if (addr == CFG_AW'(i)) begin
                    reg_d.bank[i] = wr_data & wmask(i);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign view[g] = reg_q.bank[g] | ((g == VER_ADDR) ? VER_BYTE : '0);
    end

    always_comb begin
        rdata = '0;
        for (int unsigned i = 0; i < NREG; i++) begin
            if (cmd_ok && (addr == CFG_AW'(i))) rdata = view[i];
        end
    end

    assign regs_flat = view;
endmodule

// File: rtl/spi_cfg_bank.sv
`timescale 1ns/1ps
module spi_cfg_bank
    import spi_cfg_pkg::*;
#(
    parameter int unsigned NREG     = 18,
    parameter int unsigned VER_ADDR = 1,
    parameter logic [3:0]  VERSION  = 4'h5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_csn,
    input  logic                   spi_sclk,
    input  logic                   spi_sdio_i,
    output logic                   spi_sdio_o,
    output logic                   spi_sdio_oe,
    output logic                   spi_sdo,
    output logic                   cfg_sleep,
    output logic                   cfg_pdn,
    output logic                   cfg_ext_ref,
    output logic [NREG*CFG_DW-1:0] cfg_regs
);
    logic [2:0] pins_s;
    logic       wr_stb, cmd_ok, rd_phase, dout;
    cfg_byte_t  wr_data, rdata, ctrl;
    cfg_addr_t  addr;

    spi_cfg_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn, spi_sclk, spi_sdio_i}),
        .q     (pins_s)
    );

    spi_cfg_serial i_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_s     (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .sdi_s     (pins_s[0]),
        .lsb_first (ctrl[BIT_LSBF]),
        .rdata     (rdata),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .addr      (addr),
        .cmd_ok    (cmd_ok),
        .rd_phase  (rd_phase),
        .dout      (dout)
    );

    spi_cfg_regs #(.NREG(NREG), .VER_ADDR(VER_ADDR), .VERSION(VERSION)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .addr      (addr),
        .cmd_ok    (cmd_ok),
        .rdata     (rdata),
        .regs_flat (cfg_regs)
    );

    assign ctrl        = cfg_regs[CFG_DW-1:0];
    assign spi_sdio_oe = rd_phase &  ctrl[BIT_BIDIR];
    assign spi_sdio_o  = dout     &  ctrl[BIT_BIDIR];
    assign spi_sdo     = dout     & ~ctrl[BIT_BIDIR];
    assign cfg_sleep   = ctrl[BIT_SLEEP];
    assign cfg_pdn     = ctrl[BIT_PDN];
    assign cfg_ext_ref = ctrl[BIT_EXTREF];
endmodule

// File: rtl/spi_cfg_bank_chk.sv
`timescale 1ns/1ps
module spi_cfg_bank_chk #(
    parameter int unsigned NREG = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_csn,
    input logic              spi_sdio_oe,
    input logic              spi_sdo,
    input logic [NREG*8-1:0] cfg_regs
);
    // R6: reserved control bits never become visible
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_regs[2:1] == 2'b00);

    // R4: shared line only driven in bidirectional mode
    a_r4_sdio_oe_needs_bidir: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdio_oe |-> cfg_regs[7]);

    // R4: both read lines idle once deselection has passed the synchronizer
    a_r4_lines_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2)) |-> (!spi_sdio_oe && !spi_sdo));

    // R8: software reset bit clears itself and empties the rest of the bank
    a_r8_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_regs[5] |=> (!cfg_regs[5] && (cfg_regs[NREG*8-1:16] == '0)));

    // R9: no register change without an active selection
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)
         && $past(spi_csn, 4)) |=> $stable(cfg_regs));
endmodule

bind spi_cfg_bank spi_cfg_bank_chk #(.NREG(NREG)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_sdio_oe (spi_sdio_oe),
    .spi_sdo     (spi_sdo),
    .cfg_regs    (cfg_regs)
);

// File: tb/test_spi_cfg_bank.sv
`timescale 1ns/1ps
module test_spi_cfg_bank;
    localparam int NREG = 18;
    localparam int W    = NREG * 8;
    localparam int HALF = 6;

    // {address, write data, expected read}
    localparam logic [23:0] VEC [8] = '{
        24'h02A5A5, 24'h073C3C, 24'h11FFFF, 24'h105A5A,
        24'h01FF05, 24'h127700, 24'h1FEE00, 24'h0B8181
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_csn = 1'b1, spi_sclk = 1'b0, spi_sdio_i = 1'b0;
    logic spi_sdio_o, spi_sdio_oe, spi_sdo, cfg_sleep, cfg_pdn, cfg_ext_ref;
    logic [W-1:0] cfg_regs;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0, lsb_mode = 0, bidir_mode = 0;
    logic [7:0] rv;
    logic s_oe, s_sdo;

    always #2.5 clk = ~clk;

    spi_cfg_bank i_spi_cfg_bank (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .spi_sdio_i(spi_sdio_i), .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
        .spi_sdo(spi_sdo), .cfg_sleep(cfg_sleep), .cfg_pdn(cfg_pdn),
        .cfg_ext_ref(cfg_ext_ref), .cfg_regs(cfg_regs)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] ins, input logic [7:0] wd, input logic [7:0] ext,
                        input int nbits, output logic [7:0] rd, output logic oe, output logic sdo);
        logic [23:0] bits;
        for (int i = 0; i < 8; i++) begin
            bits[i]    = lsb_mode ? ins[i] : ins[7-i];
            bits[8+i]  = lsb_mode ? wd[i]  : wd[7-i];
            bits[16+i] = lsb_mode ? ext[i] : ext[7-i];
        end
        rd = '0; oe = 1'b0; sdo = 1'b0;
        @(negedge clk) spi_csn = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sdio_i = bits[i];
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 16) begin
                if (lsb_mode) rd[i-8]  = bidir_mode ? spi_sdio_o : spi_sdo;
                else          rd[15-i] = bidir_mode ? spi_sdio_o : spi_sdo;
                oe  = oe  | spi_sdio_oe;
                sdo = sdo | spi_sdo;
            end
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (6) @(negedge clk);
        spi_csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] x; logic o, s;
        xfer({3'b000, a}, d, 8'h00, 16, x, o, s);
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        logic o, s;
        xfer({3'b100, a}, 8'h00, 8'h00, 16, d, o, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 regs", cfg_regs, W'(16'h0500));
        chk("R1 ctrl outs", W'({cfg_sleep, cfg_pdn, cfg_ext_ref, spi_sdo, spi_sdio_oe}), '0);

        // R2 R7 R10 vector walk
        foreach (VEC[k]) begin
            logic [4:0] a;
            a = VEC[k][20:16];
            wr(a, VEC[k][15:8]);
            rd(a, rv);
            chk(a == 5'h01 ? "R7 version" : (a > 5'h11 ? "R10 out of range" : "R2 readback"),
                W'(rv), W'(VEC[k][7:0]));
        end

        // R4 four-wire read uses dedicated line only
        xfer(8'h82, 8'h00, 8'h00, 16, rv, s_oe, s_sdo);
        chk("R4 sdo read", W'({rv, s_oe}), W'({8'hA5, 1'b0}));

        // R5 R6 control outputs and reserved bits
        wr(5'h00, 8'h1F);
        chk("R5 outputs", W'({cfg_sleep, cfg_pdn, cfg_ext_ref}), W'(3'b111));
        rd(5'h00, rv);
        chk("R6 reserved", W'(rv), W'(8'h19));
        wr(5'h00, 8'h00);
        chk("R5 outputs cleared", W'({cfg_sleep, cfg_pdn, cfg_ext_ref}), '0);

        // R3 least significant bit first
        wr(5'h00, 8'h40);
        lsb_mode = 1;
        wr(5'h03, 8'hC1);
        chk("R3 lsb write", W'(cfg_regs[31:24]), W'(8'hC1));
        rd(5'h03, rv);
        chk("R3 lsb read", W'(rv), W'(8'hC1));
        wr(5'h00, 8'h00);
        lsb_mode = 0;
        rd(5'h00, rv);
        chk("R3 back to msb", W'(rv), W'(8'h00));

        // R4 bidirectional read
        wr(5'h00, 8'h80);
        bidir_mode = 1;
        xfer(8'h82, 8'h00, 8'h00, 16, rv, s_oe, s_sdo);
        chk("R4 sdio read", W'({rv, s_oe, s_sdo}), W'({8'hA5, 1'b1, 1'b0}));
        wr(5'h00, 8'h00);
        bidir_mode = 0;

        // R8 software reset
        wr(5'h00, 8'h30);
        chk("R8 bank cleared", cfg_regs, W'(16'h0510));
        chk("R8 sleep kept", W'(cfg_sleep), W'(1'b1));
        wr(5'h00, 8'h00);

        // R9 aborted frame
        wr(5'h02, 8'h3C);
        xfer(8'h02, 8'h99, 8'h00, 12, rv, s_oe, s_sdo);
        rd(5'h02, rv);
        chk("R9 abort", W'(rv), W'(8'h3C));

        // R11 extra clocks
        xfer(8'h02, 8'h66, 8'hFF, 24, rv, s_oe, s_sdo);
        rd(5'h02, rv);
        chk("R11 extra bits", W'(rv), W'(8'h66));
        chk("R11 neighbour", W'(cfg_regs[31:24]), W'(8'h00));

        // R10 malformed instruction
        xfer(8'h62, 8'h11, 8'h00, 16, rv, s_oe, s_sdo);
        chk("R10 bad write", W'(cfg_regs[23:16]), W'(8'h66));
        xfer(8'hC2, 8'h00, 8'h00, 16, rv, s_oe, s_sdo);
        chk("R10 bad read", W'(rv), W'(8'h00));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule